// File: doc/BRIEF.md
# Supply Monitor and Backup Sequencer

This block watches two digitized voltage codes, one for the main supply and one for the backup cell. From them it steps the device through four conditions: normal run, an early power-fail warning, a power-fail reset, and battery backup. Every trip point is a fixed ratio of the battery code, not an absolute level. The comparisons use exact integer arithmetic on the codes. The warning trip is 29/20 of the battery code, the reset trip is 7/5 of it, and the switchover point is equal to it.

The warning stage does not stop the processor. It raises a one-cycle interrupt request that carries the fixed vector 002Bh, and only when the warning is enabled. The reset stage holds the core in reset and forces the memory strobes inactive. Once the supply recovers, a power-on delay counter keeps reset asserted for a programmable number of clocks (21504 by default) before execution resumes. Below the battery code, the memory supply select moves to the backup cell.

Each trip point has a hysteresis band of one code step. The supply must rise one full code above a threshold before the matching condition is released. This stops a noisy supply near a trip point from toggling the state.

Top module: `smon_seq`

## Requirements
- R1: While rst_n is low and on the first clock after it rises, cpu_reset, bus_inhibit and use_battery are 1 and warn_irq is 0. All three trip conditions start out as "below".
- R2: The warning condition is set on a clock where 20*vcc_code < 29*bat_code. It is cleared on a clock where 20*vcc_code >= 29*bat_code + 20. In between it holds its value.
- R3: warn_irq is a pulse one clock wide. While warn_irq is 1, warn_vec is 16'h002B. Otherwise warn_vec is 0.
- R4: warn_irq is raised only on the clock where the warning condition goes from clear to set, and only if warn_en is 1 on that clock. A supply that stays below the warning trip, or dithers inside the hysteresis band, gives no second pulse until the condition has been cleared.
- R5: The warning condition on its own affects neither cpu_reset nor bus_inhibit.
- R6: The low-supply reset condition is set when 5*vcc_code < 7*bat_code and cleared when 5*vcc_code >= 7*bat_code + 5; otherwise it holds. While it is set, both cpu_reset and bus_inhibit are 1. bus_inhibit follows this condition only.
- R7: use_battery is set when vcc_code < bat_code and cleared when vcc_code >= bat_code + 1; otherwise it holds.
- R8: After the low-supply reset condition clears, cpu_reset stays 1 for exactly POR_CYCLES clocks (default 21504) and then falls.
- R9: Every output reflects the inputs sampled at the clock edge before it. That is one register stage, with no combinational path from the inputs to the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_code | input | CODE_W | Digitized main supply level, unsigned |
| bat_code | input | CODE_W | Digitized backup cell level, unsigned |
| warn_en | input | 1 | Enables the power-fail warning interrupt |
| warn_irq | output | 1 | One-cycle warning interrupt request |
| warn_vec | output | 16 | Interrupt vector while warn_irq is high, else 0 |
| cpu_reset | output | 1 | Core reset, active high |
| bus_inhibit | output | 1 | Forces memory enables and write enable inactive |
| use_battery | output | 1 | Selects the backup cell as the memory supply |

## Verification
A single drop in supply can cross the warning trip and the reset trip on the same clock. In that case the interrupt pulse and the entry into reset fall in the same cycle. The bench provokes this by jumping the supply code straight from the top of its range to zero, and by ramping it down code by code, for every battery code of a 6-bit configuration. At each step it compares the pulse, reset and inhibit against an arithmetic model of the three hysteresis flags and the delay counter. It uses the same drops to confirm that the pulse still depends only on warn_en, and that reset does not swallow the interrupt.

// File: rtl/smon_pkg.sv
package smon_pkg;

  // Order of the trip comparators inside the sequencer.
  localparam int NUM_CMP  = 3;
  localparam int IDX_WARN = 0;
  localparam int IDX_RST  = 1;
  localparam int IDX_BAT  = 2;

  // Trip ratio of each comparator, as numerator / denominator of bat_code.
  localparam int unsigned RATIO_NUM [NUM_CMP] = '{29, 7, 1};
  localparam int unsigned RATIO_DEN [NUM_CMP] = '{20, 5, 1};

  localparam logic [15:0] WARN_VECTOR = 16'h002B;

  // Supply is under the trip point num/den * bat.
  function automatic logic code_below(input int unsigned vcc, input int unsigned bat,
                                      input int unsigned num, input int unsigned den);
    return (vcc * den) < (bat * num);
  endfunction

  // Supply is at least one code step above the trip point.
  function automatic logic code_recovered(input int unsigned vcc, input int unsigned bat,
                                          input int unsigned num, input int unsigned den);
    return (vcc * den) >= (bat * num + den);
  endfunction

endpackage

// File: rtl/smon_hcmp.sv
module smon_hcmp #(
  parameter int          CODE_W = 8,
  parameter int unsigned NUM    = 1,
  parameter int unsigned DEN    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] vcc,
  input  logic [CODE_W-1:0] bat,
  output logic              below_q
);
  logic go_low;
  logic go_high;

  always_comb begin
    go_low  = smon_pkg::code_below(32'(vcc), 32'(bat), NUM, DEN);
    go_high = smon_pkg::code_recovered(32'(vcc), 32'(bat), NUM, DEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       below_q <= 1'b1;
    else if (go_low)  below_q <= 1'b1;
    else if (go_high) below_q <= 1'b0;
  end
endmodule

// File: rtl/smon_warn.sv
module smon_warn #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] vcc,
  input  logic [CODE_W-1:0] bat,
  input  logic              armed_n,
  input  logic              enable,
  output logic              fall_evt,
  output logic              irq_q,
  output logic [15:0]       vec
);
  // A falling crossing happens only while the flag is still clear (armed).
  always_comb begin
    fall_evt = smon_pkg::code_below(32'(vcc), 32'(bat),
                                    smon_pkg::RATIO_NUM[smon_pkg::IDX_WARN],
                                    smon_pkg::RATIO_DEN[smon_pkg::IDX_WARN])
               & ~armed_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fall_evt & enable;
  end

  assign vec = irq_q ? smon_pkg::WARN_VECTOR : 16'h0000;
endmodule

// File: rtl/smon_por.sv
module smon_por #(
  parameter int unsigned POR_CYCLES = 21504
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic busy
);
  localparam int CNT_W = $clog2(POR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(POR_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= CNT_LOAD;
    else if (hold)           cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/smon_seq.sv
module smon_seq #(
  parameter int          CODE_W     = 8,
  parameter int unsigned POR_CYCLES = 21504
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] vcc_code,
  input  logic [CODE_W-1:0] bat_code,
  input  logic              warn_en,
  output logic              warn_irq,
  output logic [15:0]       warn_vec,
  output logic              cpu_reset,
  output logic              bus_inhibit,
  output logic              use_battery
);
  import smon_pkg::*;

  logic [NUM_CMP-1:0] below_vec;
  logic warn_below;
  logic rst_below;
  logic batt_below;
  logic warn_fall;
  logic por_busy;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    smon_hcmp #(
      .CODE_W (CODE_W),
      .NUM    (RATIO_NUM[g]),
      .DEN    (RATIO_DEN[g])
    ) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .vcc     (vcc_code),
      .bat     (bat_code),
      .below_q (below_vec[g])
    );
  end

  assign warn_below = below_vec[IDX_WARN];
  assign rst_below  = below_vec[IDX_RST];
  assign batt_below = below_vec[IDX_BAT];

  smon_warn #(.CODE_W(CODE_W)) u_warn (
    .clk      (clk),
    .rst_n    (rst_n),
    .vcc      (vcc_code),
    .bat      (bat_code),
    .armed_n  (warn_below),
    .enable   (warn_en),
    .fall_evt (warn_fall),
    .irq_q    (warn_irq),
    .vec      (warn_vec)
  );

  smon_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (rst_below),
    .busy  (por_busy)
  );

  assign cpu_reset   = rst_below | por_busy;
  assign bus_inhibit = rst_below;
  assign use_battery = batt_below;
endmodule

// File: rtl/smon_seq_chk.sv
module smon_seq_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] vcc_code,
  input logic [CODE_W-1:0] bat_code,
  input logic              warn_en,
  input logic              warn_irq,
  input logic [15:0]       warn_vec,
  input logic              cpu_reset,
  input logic              bus_inhibit,
  input logic              use_battery,
  input logic              warn_below
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |=> !warn_irq);

  a_r3_vector_on: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |-> warn_vec == 16'h002B);

  a_r3_vector_off: assert property (@(posedge clk) disable iff (!rst_n)
    !warn_irq |-> warn_vec == 16'h0000);

  a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |-> $past(warn_en));

  a_r2_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |-> warn_below);

  a_r6_inhibit_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    bus_inhibit |-> cpu_reset);

  a_r8_reset_outlasts: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_inhibit) |-> cpu_reset);

  a_r7_switch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(use_battery) |-> $past(vcc_code < bat_code));
endmodule

bind smon_seq smon_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vcc_code    (vcc_code),
  .bat_code    (bat_code),
  .warn_en     (warn_en),
  .warn_irq    (warn_irq),
  .warn_vec    (warn_vec),
  .cpu_reset   (cpu_reset),
  .bus_inhibit (bus_inhibit),
  .use_battery (use_battery),
  .warn_below  (warn_below)
);

// File: tb/smon_seq_tb_top.sv
`timescale 1ns/1ps
module smon_seq_tb_top;
  localparam int CW  = 6;
  localparam int POR = 21504;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] vcc_code = '0;
  logic [CW-1:0] bat_code = '0;
  logic          warn_en = 1'b0;
  logic          warn_irq;
  logic [15:0]   warn_vec;
  logic          cpu_reset;
  logic          bus_inhibit;
  logic          use_battery;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model state
  bit m_warn, m_rst, m_bat, e_irq;
  int m_por;

  always #2.5 clk = ~clk;

  smon_seq #(.CODE_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .vcc_code(vcc_code), .bat_code(bat_code),
    .warn_en(warn_en), .warn_irq(warn_irq), .warn_vec(warn_vec),
    .cpu_reset(cpu_reset), .bus_inhibit(bus_inhibit), .use_battery(use_battery)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (vcc=%0d bat=%0d)",
               req, act, exp, vcc_code, bat_code);
    end
  endtask

  task automatic check_all();
    chk("R3/R4 irq", int'(warn_irq), int'(e_irq));
    chk("R3 vec", int'(warn_vec), e_irq ? 32'h2B : 0);
    chk("R6/R8 reset", int'(cpu_reset), int'(m_rst || m_por != 0));
    chk("R6 inhibit", int'(bus_inhibit), int'(m_rst));
    chk("R7 battery", int'(use_battery), int'(m_bat));
  endtask

  // Called at a falling edge: drive, model one clock (R9), sample after it.
  task automatic step(input int v, input int b, input bit en);
    vcc_code = CW'(v);
    bat_code = CW'(b);
    warn_en  = en;
    e_irq = en && !m_warn && (v*20 < b*29);
    if (v*20 < b*29) m_warn = 1; else if (v*20 >= b*29 + 20) m_warn = 0;   // R2
    m_por = m_rst ? POR : (m_por > 0 ? m_por - 1 : 0);                      // R8
    if (v*5 < b*7) m_rst = 1; else if (v*5 >= b*7 + 5) m_rst = 0;           // R6
    if (v < b) m_bat = 1; else if (v >= b + 1) m_bat = 0;                   // R7
    @(posedge clk);
    #1;
    check_all();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int hi_cnt;
    m_warn = 1; m_rst = 1; m_bat = 1; m_por = POR; e_irq = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 reset", int'(cpu_reset), 1);
    chk("R1 inhibit", int'(bus_inhibit), 1);
    chk("R1 battery", int'(use_battery), 1);
    chk("R1 irq", int'(warn_irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 1'b0);
    chk("R1 first clock reset", int'(cpu_reset), 1);

    // Sweep every battery code: ramp up, ramp down, then a sudden drop
    // that crosses warning and reset trips on the same clock.
    for (int b = 0; b <= MAXC; b++) begin
      bit en = (b % 3) != 0;
      for (int v = 0; v <= MAXC; v++) step(v, b, en);
      for (int v = MAXC; v >= 0; v--) step(v, b, en);
      step(MAXC, b, en);
      step(0, b, en);
    end

    // R8: power-on delay after supply recovers.
    step(MAXC, 20, 1'b1);
    hi_cnt = 0;
    while (cpu_reset && hi_cnt < POR + 10) begin
      hi_cnt++;
      step(MAXC, 20, 1'b1);
    end
    chk("R8 hold length", hi_cnt, POR);

    // R5: warning alone. bat=20 -> warn below at vcc<=28, reset at vcc<=27.
    step(28, 20, 1'b1);
    chk("R5 irq on warn", int'(warn_irq), 1);
    chk("R5 no reset on warn", int'(cpu_reset), 0);
    // R4: dither in band gives no second pulse
    step(29, 20, 1'b1);
    step(28, 20, 1'b1);
    chk("R4 no re-pulse in band", int'(warn_irq), 0);
    step(30, 20, 1'b1);
    step(28, 20, 1'b0);
    chk("R4 disabled crossing", int'(warn_irq), 0);
    step(30, 20, 1'b1);
    step(28, 20, 1'b1);
    chk("R4 re-armed pulse", int'(warn_irq), 1);
    // R6 hysteresis on reset trip
    step(27, 20, 1'b1);
    chk("R6 reset entered", int'(bus_inhibit), 1);
    step(28, 20, 1'b1);
    chk("R6 holds in band", int'(bus_inhibit), 1);
    step(29, 20, 1'b1);
    chk("R6 released", int'(bus_inhibit), 0);
    chk("R8 still in delay", int'(cpu_reset), 1);
    // R7 battery switchover band
    step(19, 20, 1'b1);
    chk("R7 switch to battery", int'(use_battery), 1);
    step(20, 20, 1'b1);
    chk("R7 holds at equal", int'(use_battery), 1);
    step(21, 20, 1'b1);
    chk("R7 back to supply", int'(use_battery), 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule